// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves data between two bidirectional buses, A and B, through one holding register per direction. Each direction has its own capture clock, an active-low chip enable and an active-low output enable. A capture stores the level on the source bus. The destination bus then shows that stored value for as long as both enables of that direction are low. When either enable is high, the destination bus is released to high impedance.

The pins of each direction are sampled by a fast system clock through a synchronizer. The capture clock of a direction is qualified by its chip enable: the capture event is a rising edge of the OR of the two. This has a side effect. If the chip enable rises while the capture clock is low, that rise is taken as a capture. The source bus data passes through the same number of sampling stages as the controls, so a capture takes the bus level present when the control edge happened. If both directions drive at the same time, a conflict flag goes high. The drive is not resolved in either direction.

Top module: `regbus_xcvr`

## Requirements
- R1: After reset both holding registers read 0x00, neither bus is driven and `conflict_o` is 0. Lowering a chip enable while its clock is low does not capture, so a direction enabled straight after reset presents 0x00.
- R2: With `ab_ce_ni` low, a rising edge on `ab_clk_i` stores the level on A. With `ab_oe_ni` also low, B presents that value within SYNC_STAGES+2 system clocks.
- R3: With `ba_ce_ni` low, a rising edge on `ba_clk_i` stores the level on B. With `ba_oe_ni` also low, A presents it, with the same timing as R2.
- R4: When there is no capture event, a direction keeps presenting its stored value while its source bus changes.
- R5: When a direction's chip enable is high, its destination bus is not driven.
- R6: When a direction's output enable is high, its destination bus is not driven. Captures still take place while the output enable is high.
- R7: While a direction's chip enable is high, clock edges and source changes do not alter its register. Lowering the chip enable while the clock is high does not capture.
- R8: If a chip enable rises while its clock is low, the register captures the source level at that moment.
- R9: Activity in one direction never changes the register of the other direction.
- R10: `conflict_o` is 1 exactly when both directions drive at once. In that state A carries the B-to-A register and B carries the A-to-B register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all controls |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_io | inout | WIDTH | Bus A: source for A-to-B, destination for B-to-A |
| b_io | inout | WIDTH | Bus B: source for B-to-A, destination for A-to-B |
| ab_clk_i | input | 1 | A-to-B capture clock |
| ab_ce_ni | input | 1 | A-to-B chip enable, active low |
| ab_oe_ni | input | 1 | A-to-B output enable, active low |
| ba_clk_i | input | 1 | B-to-A capture clock |
| ba_ce_ni | input | 1 | B-to-A chip enable, active low |
| ba_oe_ni | input | 1 | B-to-A output enable, active low |
| conflict_o | output | 1 | High while both directions drive |

## Verification
The bench uses the defaults, WIDTH=8 and SYNC_STAGES=2. At these values the capture latency is short, so every control change can be followed by a settle window of a few clocks, and data patterns can use all eight bits. A bus that should be released is checked by having the bench drive the complement of the stored value and reading back the bench's own value. A released bus and a driven one therefore read differently. The false-capture and no-capture orderings of chip enable against clock are each driven as separate sequences.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
  typedef struct packed {
    logic clk;
    logic ce_n;
    logic oe_n;
  } dir_ctrl_t;

  localparam int unsigned CTRL_W = $bits(dir_ctrl_t);
  localparam dir_ctrl_t CTRL_IDLE = '{clk: 1'b0, ce_n: 1'b1, oe_n: 1'b1};
endpackage

// File: rtl/regbus_sync.sv
module regbus_sync #(
  parameter int unsigned    WIDTH   = 1,
  parameter int unsigned    STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  if (STAGES < 2) begin : g_single
    logic [WIDTH-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) q <= RST_VAL;
      else         q <= d_i;
    assign q_o = q;
  end else begin : g_chain
    logic [STAGES-1:0][WIDTH-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) q <= {STAGES{RST_VAL}};
      else         q <= {q[STAGES-2:0], d_i};
    assign q_o = q[STAGES-1];
  end
endmodule

// File: rtl/regbus_dir.sv
module regbus_dir
  import regbus_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  dir_ctrl_t        ctrl_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] hold_o,
  output logic             drive_o
);
  dir_ctrl_t        ctrl_s;
  logic [WIDTH-1:0] data_d;
  logic [WIDTH-1:0] hold_q;
  logic             qual_s, qual_q, cap_stb;

  regbus_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_IDLE)) u_ctrl_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ctrl_i), .q_o(ctrl_s)
  );

  // data delayed by the same depth so a capture sees the level at the control edge
  regbus_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(data_i), .q_o(data_d)
  );

  // enable-qualified clock: a CE rise with CLK low is a capture edge
  assign qual_s  = ctrl_s.clk | ctrl_s.ce_n;
  assign cap_stb = qual_s & ~qual_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      qual_q <= 1'b1;
      hold_q <= '0;
    end else begin
      qual_q <= qual_s;
      if (cap_stb) hold_q <= data_d;
    end

  assign hold_o  = hold_q;
  assign drive_o = ~ctrl_s.ce_n & ~ctrl_s.oe_n;

  // R4
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_stb |=> $stable(hold_q));
  // R7
  ce_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_s.ce_n && $past(ctrl_s.ce_n)) |-> !cap_stb);
  // R2
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_stb |=> !cap_stb);
  // R8
  capture_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_stb |=> hold_q == $past(data_d));
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
  import regbus_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  inout  wire  [WIDTH-1:0] a_io,
  inout  wire  [WIDTH-1:0] b_io,
  input  logic             ab_clk_i,
  input  logic             ab_ce_ni,
  input  logic             ab_oe_ni,
  input  logic             ba_clk_i,
  input  logic             ba_ce_ni,
  input  logic             ba_oe_ni,
  output logic             conflict_o
);
  localparam int unsigned NDIR = 2;  // 0: A to B, 1: B to A

  dir_ctrl_t        ctrl  [NDIR];
  logic [WIDTH-1:0] src   [NDIR];
  logic [WIDTH-1:0] hold  [NDIR];
  logic [NDIR-1:0]  drive;

  assign ctrl[0] = '{clk: ab_clk_i, ce_n: ab_ce_ni, oe_n: ab_oe_ni};
  assign ctrl[1] = '{clk: ba_clk_i, ce_n: ba_ce_ni, oe_n: ba_oe_ni};
  assign src[0]  = a_io;
  assign src[1]  = b_io;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    regbus_dir #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_dir (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ctrl_i (ctrl[d]),
      .data_i (src[d]),
      .hold_o (hold[d]),
      .drive_o(drive[d])
    );
  end

  assign b_io       = drive[0] ? hold[0] : {WIDTH{1'bz}};
  assign a_io       = drive[1] ? hold[1] : {WIDTH{1'bz}};
  assign conflict_o = &drive;
endmodule

// File: tb/regbus_xcvr_bench.sv
`timescale 1ns/1ps
module regbus_xcvr_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       ab_clk = 0, ab_ce_n = 1, ab_oe_n = 1;
  logic       ba_clk = 0, ba_ce_n = 1, ba_oe_n = 1;
  logic       a_en = 0, b_en = 0;
  logic [7:0] a_drv = 0, b_drv = 0;
  logic       conflict;
  wire  [7:0] a_bus, b_bus;

  assign a_bus = a_en ? a_drv : 8'hzz;
  assign b_bus = b_en ? b_drv : 8'hzz;

  regbus_xcvr u_regbus_xcvr (
    .clk_i(clk), .rst_ni(rst_n), .a_io(a_bus), .b_io(b_bus),
    .ab_clk_i(ab_clk), .ab_ce_ni(ab_ce_n), .ab_oe_ni(ab_oe_n),
    .ba_clk_i(ba_clk), .ba_ce_ni(ba_ce_n), .ba_oe_ni(ba_oe_n),
    .conflict_o(conflict)
  );

  int checks = 0, failures = 0;
  logic [7:0] exp_ab = 0, exp_ba = 0;

  // {direction (0: A to B), data}
  localparam logic [8:0] VEC [8] = '{
    {1'b0, 8'h5A}, {1'b0, 8'hFF}, {1'b1, 8'hC3}, {1'b1, 8'h00},
    {1'b0, 8'h01}, {1'b1, 8'h80}, {1'b0, 8'hA5}, {1'b1, 8'h3C}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic mode_ab();
    ba_oe_n = 1; settle();
    b_en = 0; a_en = 1; ab_oe_n = 0; settle();
  endtask

  task automatic mode_ba();
    ab_oe_n = 1; settle();
    a_en = 0; b_en = 1; ba_oe_n = 0; settle();
  endtask

  task automatic pulse_ab();
    ab_clk = 1; settle(); ab_clk = 0; settle();
  endtask

  task automatic pulse_ba();
    ba_clk = 1; settle(); ba_clk = 0; settle();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1; settle();

    // R1: nothing driven after reset
    chk("R1 conflict idle", {7'd0, conflict}, 8'h00);
    a_en = 1; a_drv = 8'h96; b_en = 1; b_drv = 8'h69; settle();
    chk("R1 A released", a_bus, 8'h96);
    chk("R1 B released", b_bus, 8'h69);
    a_en = 0; b_en = 0;

    // R1: enabling with clock low captures nothing, registers read zero
    ab_ce_n = 0; ba_ce_n = 0; settle();
    mode_ab();
    chk("R1 A-to-B reset value", b_bus, 8'h00);
    mode_ba();
    chk("R1 B-to-A reset value", a_bus, 8'h00);

    // R2 / R3: vector walk
    foreach (VEC[i]) begin
      if (!VEC[i][8]) begin
        mode_ab(); a_drv = VEC[i][7:0]; settle(); pulse_ab();
        exp_ab = VEC[i][7:0];
        chk("R2 A-to-B capture", b_bus, exp_ab);
      end else begin
        mode_ba(); b_drv = VEC[i][7:0]; settle(); pulse_ba();
        exp_ba = VEC[i][7:0];
        chk("R3 B-to-A capture", a_bus, exp_ba);
      end
    end

    // R4: hold while source changes
    mode_ab();
    a_drv = ~exp_ab; settle();
    chk("R4 hold without edge", b_bus, exp_ab);

    // R2 with clock left high, then R5 / R7
    a_drv = 8'h71; settle();
    ab_clk = 1; settle(); exp_ab = 8'h71;
    chk("R2 capture on rise", b_bus, exp_ab);
    ab_ce_n = 1; settle();
    b_en = 1; b_drv = ~exp_ab; settle();
    chk("R5 released by chip enable", b_bus, ~exp_ab);
    a_drv = 8'h0F; settle();
    ab_clk = 0; settle(); ab_clk = 1; settle();
    b_en = 0;
    ab_ce_n = 0; settle();
    chk("R7 no capture while disabled", b_bus, exp_ab);
    ab_clk = 0; settle();
    chk("R7 clock fall no capture", b_bus, exp_ab);

    // R6: output enable releases but capture continues
    ab_oe_n = 1; settle();
    b_en = 1; b_drv = ~exp_ab; settle();
    chk("R6 released by output enable", b_bus, ~exp_ab);
    a_drv = 8'hE2; settle(); pulse_ab(); exp_ab = 8'hE2;
    b_en = 0; ab_oe_n = 0; settle();
    chk("R6 capture while released", b_bus, exp_ab);

    // R8: chip enable rise with clock low captures
    a_drv = 8'h4B; settle();
    ab_ce_n = 1; settle(); exp_ab = 8'h4B;
    a_drv = 8'hB4; settle();
    ab_ce_n = 0; settle();
    chk("R8 false capture edge", b_bus, exp_ab);

    // R9: B-to-A register untouched by A-to-B activity
    mode_ba();
    chk("R9 independence", a_bus, exp_ba);

    // R10: both directions driving
    b_en = 0; ab_oe_n = 0; settle();
    chk("R10 conflict flag", {7'd0, conflict}, 8'h01);
    chk("R10 A value", a_bus, exp_ba);
    chk("R10 B value", b_bus, exp_ab);
    ba_oe_n = 1; settle();
    chk("R10 conflict clears", {7'd0, conflict}, 8'h00);

    // R1: reset during operation
    @(negedge clk); rst_n = 0; repeat (2) @(negedge clk); rst_n = 1; settle();
    chk("R1 mid-run reset", b_bus, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule